// File: doc/BRIEF.md
# Quad Wiper Register Bank Controller

This block holds the register file and command handling for four potentiometer channels. Each channel owns one volatile wiper position, which drives the tap decoder, and four retained data bytes. The retained bytes are modelled as flip-flops that keep their contents through reset. A serial front end that has already framed bytes feeds the block: an address byte, data bytes, read requests and the stop event. A separate single-channel adjust interface can ask for the current wiper of one channel to be saved.

A small volatile control byte picks the register class for every channel access. The byte address only selects the channel. With retained storage selected, data bytes go straight to the channel's wiper and are also staged. On stop they are committed as one page, provided the write-protect input allows it, and a timed busy window follows. Reading a retained byte also copies it into that channel's wiper, so a read can move the wiper. Reset stands in for power-up: every wiper reloads from its channel's data byte 0.

The front end presents at most one of `addr_valid`, `wr_valid` and `rd_req` per cycle. If more than one is set, the address wins over a data byte, and a data byte wins over a read.

Top module: `wiper_bank`

## Requirements
- R1: While `rst` is high, the control byte clears to 00h and the channel pointer returns to channel 0 with channel access selected. Busy, `rd_valid` and `rejected` go low, and each wiper reloads from its channel's data byte 0.
- R2: Only bits 2:0 of the address byte are decoded. Values 0 to 3 select channels 0 to 3, and 7 selects the control byte. Values 4 to 6 reach nothing: writes there change no register, and reads there return 00h.
- R3: The control byte keeps only written bits 2:0: bit 0 selects retained storage, and bits 2:1 give the page. Its upper bits read as 0. With bit 0 clear, channel accesses read and write the wiper, whatever the page bits hold.
- R4: With bit 0 set, a channel read returns data byte [page] of the pointed channel. The same edge loads that value into the channel's wiper.
- R5: With bit 0 set, a data byte to a channel loads that channel's wiper at once and stages the byte for the channel.
- R6: Every data byte or read that addresses a channel advances the pointer by one, wrapping from channel 3 to channel 0. The page stays fixed, and a fifth byte overwrites the first byte's stage.
- R7: A stop with at least one staged byte and `wp_en` high writes only the staged channels into the page. Busy then goes high for exactly BUSY_CYCLES cycles, starting the cycle after the stop.
- R8: A stop with `wp_en` low drops the staged bytes. The retained bytes stay unchanged and busy stays low, while the wipers keep the values already written.
- R9: While busy, address bytes, data bytes, reads and save requests have no effect. Each of them raises `rejected` for the following cycle, and the wipers hold.
- R10: A save request with the block idle, page bits 00 and `wp_en` high writes the chosen channel's wiper into its data byte 0 and starts the busy window. With page bits other than 00 the request is refused with `rejected`, and with `wp_en` low it does nothing.
- R11: `rd_valid` pulses for the one cycle after an accepted read, with `rd_data` holding the byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also performs the wiper recall |
| wp_en | input | 1 | High permits writes to retained storage |
| addr_valid | input | 1 | Address byte present this cycle |
| addr_byte | input | 8 | Address byte from the serial front end |
| wr_valid | input | 1 | Data byte present this cycle |
| wr_byte | input | DATA_W | Data byte to write |
| rd_req | input | 1 | Request for the next read byte |
| stop | input | 1 | Stop event closing a transfer |
| store_req | input | 1 | Save request from the adjust interface |
| store_chan | input | PTR_W | Channel whose wiper is saved |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | DATA_W | Read byte |
| rejected | output | 1 | Previous cycle's request was refused |
| busy | output | 1 | Retained write window in progress |
| wiper_pos | output | NCH*DATA_W | Wiper positions, channel i at bits i*DATA_W upward |

## Verification
A behavioural model in the bench steps alongside the design every clock. It tracks which retained bytes are known, so no value is compared before it has been defined. The main page path runs with a full page, with five bytes that start mid-page, and with a single byte. These three show apart wrap-around, overwrite and the commit of valid entries only. The same traffic then runs with write-protect low and again with retained storage off, which separates the staged path from the volatile one. Reads with retained storage on show that a read also moves the wiper. Save requests under each page and write-protect setting, and accesses during busy, exercise the refusal rules.

// File: rtl/wbank_pkg.sv
package wbank_pkg;

    localparam int          PAGE_W      = 2;
    localparam int          NUM_PAGES   = 1 << PAGE_W;
    localparam logic [2:0]  CTRL_ADDR   = 3'd7;

    // Control byte layout: page in bits 2:1, retained-select in bit 0
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              nv_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CHAN = 2'd1,
        TGT_CTRL = 2'd2
    } target_e;

    function automatic target_e decode_target(input logic [2:0] a, input int unsigned nch);
        if (a == CTRL_ADDR)
            return TGT_CTRL;
        if ({29'd0, a} < nch)
            return TGT_CHAN;
        return TGT_NONE;
    endfunction

endpackage

// File: rtl/wbank_busy_timer.sv
module wbank_busy_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/wbank_stage.sv
module wbank_stage #(
    parameter int NCH    = 4,
    parameter int DATA_W = 8,
    parameter int PTR_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NCH-1:0]        valid,
    output logic [NCH*DATA_W-1:0] data
);
    for (genvar i = 0; i < NCH; i++) begin : g_entry
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clear)
                v_q <= 1'b0;
            else if (hit)
                v_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit)
                d_q <= wr_data;
        end

        assign valid[i]                = v_q;
        assign data[i*DATA_W +: DATA_W] = d_q;
    end

endmodule

// File: rtl/wbank_channel.sv
module wbank_channel
    import wbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wiper_ld,
    input  logic [DATA_W-1:0] wiper_din,
    input  logic              dr_we,
    input  logic [PAGE_W-1:0] dr_idx,
    input  logic [DATA_W-1:0] dr_din,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] wiper_q,
    output logic [DATA_W-1:0] dr_q
);
    // Retained bytes: deliberately not reset, they survive a power cycle
    logic [DATA_W-1:0] dr_mem [NUM_PAGES];

    always_ff @(posedge clk) begin
        if (dr_we)
            dr_mem[dr_idx] <= dr_din;
    end

    always_ff @(posedge clk) begin
        if (rst)
            wiper_q <= dr_mem[0];
        else if (wiper_ld)
            wiper_q <= wiper_din;
    end

    assign dr_q = dr_mem[rd_idx];

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wbank_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 500000,
    localparam int PTR_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wp_en,
    input  logic                  addr_valid,
    input  logic [7:0]            addr_byte,
    input  logic                  wr_valid,
    input  logic [DATA_W-1:0]     wr_byte,
    input  logic                  rd_req,
    input  logic                  stop,
    input  logic                  store_req,
    input  logic [PTR_W-1:0]      store_chan,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rejected,
    output logic                  busy,
    output logic [NCH*DATA_W-1:0] wiper_pos
);
    localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NCH - 1);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_CH) ? '0 : p + 1'b1;
    endfunction

    ctrl_t              ctrl_q;
    target_e            tgt_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [PAGE_W-1:0]  stage_page_q;
    logic               rd_valid_q;
    logic [DATA_W-1:0]  rd_data_q;
    logic               rej_q;

    logic [NCH-1:0]        stg_valid;
    logic [NCH*DATA_W-1:0] stg_data;
    logic [DATA_W-1:0]     wiper_q [NCH];
    logic [DATA_W-1:0]     dr_q    [NCH];

    logic      accept, do_addr, do_wr, do_rd, do_stop;
    logic      chan_wr, chan_rd, stage_wr, commit, store_ok, busy_load, rej_d;
    target_e   addr_tgt;
    logic [DATA_W-1:0] rd_word;

    // ---------------- request qualification ----------------
    always_comb begin
        accept   = !busy;
        do_addr  = accept && addr_valid;
        do_wr    = accept && wr_valid && !addr_valid;
        do_rd    = accept && rd_req && !addr_valid && !wr_valid;
        do_stop  = accept && stop;
        addr_tgt = decode_target(addr_byte[2:0], NCH);

        chan_wr  = do_wr && (tgt_q == TGT_CHAN);
        chan_rd  = do_rd && (tgt_q == TGT_CHAN);
        stage_wr = chan_wr && ctrl_q.nv_en;

        commit   = do_stop && wp_en && (|stg_valid);
        store_ok = accept && store_req && !commit && (ctrl_q.page == '0) && wp_en;
        busy_load = commit || store_ok;

        rej_d = (busy && (addr_valid || wr_valid || rd_req || store_req)) ||
                (!busy && store_req && (commit || (ctrl_q.page != '0)));
    end

    // ---------------- read data selection ----------------
    always_comb begin
        unique case (tgt_q)
            TGT_CTRL: rd_word = {{(DATA_W-3){1'b0}}, ctrl_q};
            TGT_CHAN: rd_word = ctrl_q.nv_en ? dr_q[ptr_q] : wiper_q[ptr_q];
            default:  rd_word = '0;
        endcase
    end

    // ---------------- command state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            tgt_q        <= TGT_CHAN;
            ptr_q        <= '0;
            stage_page_q <= '0;
            rd_valid_q   <= 1'b0;
            rd_data_q    <= '0;
            rej_q        <= 1'b0;
        end else begin
            rd_valid_q <= do_rd;
            rej_q      <= rej_d;
            if (do_rd)
                rd_data_q <= rd_word;

            if (do_addr) begin
                tgt_q <= addr_tgt;
                if (addr_tgt == TGT_CHAN)
                    ptr_q <= addr_byte[PTR_W-1:0];
            end else if (chan_wr || chan_rd) begin
                ptr_q <= ptr_next(ptr_q);
            end

            if (do_wr && (tgt_q == TGT_CTRL))
                ctrl_q <= ctrl_t'(wr_byte[2:0]);

            if (stage_wr)
                stage_page_q <= ctrl_q.page;
        end
    end

    // ---------------- staging buffer ----------------
    wbank_stage #(
        .NCH    (NCH),
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) u_stage (
        .clk     (clk),
        .rst     (rst),
        .clear   (do_stop),
        .wr_en   (stage_wr),
        .wr_idx  (ptr_q),
        .wr_data (wr_byte),
        .valid   (stg_valid),
        .data    (stg_data)
    );

    // ---------------- busy window ----------------
    wbank_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (busy_load),
        .busy (busy)
    );

    // ---------------- channels ----------------
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic              sel;
        logic              wiper_ld;
        logic [DATA_W-1:0] wiper_din;
        logic              dr_we;
        logic [PAGE_W-1:0] dr_idx;
        logic [DATA_W-1:0] dr_din;

        always_comb begin
            sel       = (ptr_q == PTR_W'(i));
            wiper_ld  = sel && (chan_wr || (chan_rd && ctrl_q.nv_en));
            wiper_din = do_wr ? wr_byte : dr_q[i];
            dr_we     = (commit && stg_valid[i]) ||
                        (store_ok && (store_chan == PTR_W'(i)));
            dr_idx    = commit ? stage_page_q : '0;
            dr_din    = commit ? stg_data[i*DATA_W +: DATA_W] : wiper_q[i];
        end

        wbank_channel #(
            .DATA_W (DATA_W)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wiper_ld  (wiper_ld),
            .wiper_din (wiper_din),
            .dr_we     (dr_we),
            .dr_idx    (dr_idx),
            .dr_din    (dr_din),
            .rd_idx    (ctrl_q.page),
            .wiper_q   (wiper_q[i]),
            .dr_q      (dr_q[i])
        );

        assign wiper_pos[i*DATA_W +: DATA_W] = wiper_q[i];
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign rejected = rej_q;

endmodule

// File: rtl/wbank_checker.sv
module wbank_checker #(
    parameter int NCH         = 4,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 500000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  addr_valid,
    input logic                  wr_valid,
    input logic                  rd_req,
    input logic                  stop,
    input logic                  store_req,
    input logic                  busy,
    input logic                  rejected,
    input logic                  rd_valid,
    input logic [NCH*DATA_W-1:0] wiper_pos
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run <= 0;
        else if (busy)
            busy_run <= busy_run + 1;
        else
            busy_run <= 0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !rd_valid && !rejected));

    assert_busy_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop || store_req));

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BUSY_CYCLES);

    assert_reject_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && (addr_valid || wr_valid || rd_req || store_req)) |=> rejected);

    assert_wiper_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wiper_pos));

    assert_rd_source_R11: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));

    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !busy && !addr_valid && !wr_valid) |=> rd_valid);

endmodule

bind wiper_bank wbank_checker #(
    .NCH         (NCH),
    .DATA_W      (DATA_W),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .wr_valid   (wr_valid),
    .rd_req     (rd_req),
    .stop       (stop),
    .store_req  (store_req),
    .busy       (busy),
    .rejected   (rejected),
    .rd_valid   (rd_valid),
    .wiper_pos  (wiper_pos)
);

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
    localparam int NCH = 4;
    localparam int W   = 8;
    localparam int BC  = 24;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1, wp_en = 1'b1;
    logic         addr_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, stop = 1'b0, store_req = 1'b0;
    logic [7:0]   addr_byte = '0;
    logic [W-1:0] wr_byte = '0;
    logic [1:0]   store_chan = '0;
    logic         rd_valid, rejected, busy;
    logic [W-1:0] rd_data;
    logic [NCH*W-1:0] wiper_pos;

    wiper_bank #(.NCH(NCH), .DATA_W(W), .BUSY_CYCLES(BC)) u_dut (
        .clk(clk), .rst(rst), .wp_en(wp_en), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req), .stop(stop),
        .store_req(store_req), .store_chan(store_chan), .rd_valid(rd_valid),
        .rd_data(rd_data), .rejected(rejected), .busy(busy), .wiper_pos(wiper_pos)
    );

    int tests = 0, fails = 0;

    function automatic void check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endfunction

    function automatic int wip(int i);
        return int'(wiper_pos[i*W +: W]);
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_dr [NCH][4];
    bit m_drk[NCH][4];
    int m_wip[NCH];
    bit m_wk [NCH];
    int m_stg[NCH];
    bit m_sv [NCH];
    int m_spage, m_ctrl, m_ptr, m_tgt, m_cnt, m_rdd;
    bit m_rdv, m_rdk, m_rej;

    always @(posedge clk) begin
        int a, pg, v;
        bit nv, anyv, cmt;
        if (rst) begin
            m_ctrl = 0; m_ptr = 0; m_tgt = 1; m_cnt = 0;
            m_rdv = 0; m_rej = 0; m_rdd = 0; m_rdk = 1;
            for (int i = 0; i < NCH; i++) begin
                m_sv[i] = 0; m_wip[i] = m_dr[i][0]; m_wk[i] = m_drk[i][0];
            end
        end else begin
            pg = (m_ctrl >> 1) & 3;
            nv = m_ctrl[0];
            m_rdv = 0; m_rej = 0; cmt = 0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (addr_valid || wr_valid || rd_req || store_req) m_rej = 1;
            end else begin
                if (addr_valid) begin
                    a = addr_byte & 7;
                    if (a == 7) m_tgt = 2;
                    else if (a < NCH) begin m_tgt = 1; m_ptr = a; end
                    else m_tgt = 0;
                end else if (wr_valid) begin
                    if (m_tgt == 2) m_ctrl = wr_byte & 7;
                    else if (m_tgt == 1) begin
                        m_wip[m_ptr] = wr_byte; m_wk[m_ptr] = 1;
                        if (nv) begin m_stg[m_ptr] = wr_byte; m_sv[m_ptr] = 1; m_spage = pg; end
                        m_ptr = (m_ptr + 1) % NCH;
                    end
                end else if (rd_req) begin
                    m_rdv = 1;
                    if (m_tgt == 2) begin m_rdd = m_ctrl; m_rdk = 1; end
                    else if (m_tgt == 0) begin m_rdd = 0; m_rdk = 1; end
                    else begin
                        if (nv) begin
                            m_rdd = m_dr[m_ptr][pg]; m_rdk = m_drk[m_ptr][pg];
                            m_wip[m_ptr] = m_rdd; m_wk[m_ptr] = m_rdk;
                        end else begin
                            m_rdd = m_wip[m_ptr]; m_rdk = m_wk[m_ptr];
                        end
                        m_ptr = (m_ptr + 1) % NCH;
                    end
                end
                if (stop) begin
                    anyv = 0;
                    for (int i = 0; i < NCH; i++) anyv |= m_sv[i];
                    if (wp_en && anyv) begin
                        cmt = 1; m_cnt = BC;
                        for (int i = 0; i < NCH; i++)
                            if (m_sv[i]) begin m_dr[i][m_spage] = m_stg[i]; m_drk[i][m_spage] = 1; end
                    end
                    for (int i = 0; i < NCH; i++) m_sv[i] = 0;
                end
                if (store_req) begin
                    if (cmt || pg != 0) m_rej = 1;
                    else if (wp_en) begin
                        v = int'(store_chan);
                        m_dr[v][0] = m_wip[v]; m_drk[v][0] = m_wk[v]; m_cnt = BC;
                    end
                end
            end
        end
    end

    bit started = 0;
    always @(negedge clk) begin
        if (started && !rst) begin
            check("R7 busy vs model", int'(busy), int'(m_cnt != 0));
            check("R9 rejected vs model", int'(rejected), int'(m_rej));
            check("R11 rd_valid vs model", int'(rd_valid), int'(m_rdv));
            if (m_rdv && m_rdk) check("R4 rd_data vs model", int'(rd_data), m_rdd);
            for (int i = 0; i < NCH; i++)
                if (m_wk[i]) check("R5 wiper vs model", wip(i), m_wip[i]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_addr(input logic [7:0] a);
        @(negedge clk); addr_valid = 1'b1; addr_byte = a;
        @(negedge clk); addr_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_byte = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic read_byte(output int v);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check("R11 rd_valid after read", int'(rd_valid), 1);
        v = int'(rd_data);
    endtask

    task automatic send_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic send_store(input logic [1:0] ch);
        @(negedge clk); store_req = 1'b1; store_chan = ch;
        @(negedge clk); store_req = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        send_addr(8'h07); send_byte(c);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, n;
        int snap[NCH];
        repeat (3) @(negedge clk);
        rst = 1'b0; started = 1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        send_addr(8'h07); read_byte(v);
        check("R1 control byte cleared", v, 0);

        // R5 / R7: full page 0 write and commit
        set_ctrl(8'h01);
        send_addr(8'h00);
        send_byte(8'h10); send_byte(8'h21); send_byte(8'h32); send_byte(8'h43);
        check("R5 wiper0 loaded at byte", wip(0), 'h10);
        check("R5 wiper3 loaded at byte", wip(3), 'h43);
        send_stop();
        check("R7 busy after stop", int'(busy), 1);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R7 busy length", n, BC);

        // R3 volatile write, R1 recall
        set_ctrl(8'h00);
        send_addr(8'h01); send_byte(8'h55);
        check("R3 volatile wiper write", wip(1), 'h55);
        do_reset();
        check("R1 recall ch0", wip(0), 'h10);
        check("R1 recall ch1", wip(1), 'h21);
        check("R1 recall ch3", wip(3), 'h43);
        read_byte(v);
        check("R1 pointer at channel 0", v, 'h10);

        // R8 write-protect discards
        set_ctrl(8'h01);
        send_addr(8'h00); send_byte(8'hEE);
        check("R8 wiper keeps written value", wip(0), 'hEE);
        wp_en = 1'b0; send_stop();
        check("R8 no busy when protected", int'(busy), 0);
        wp_en = 1'b1;
        send_addr(8'h00); read_byte(v);
        check("R8 retained byte unchanged", v, 'h10);
        check("R4 read loads wiper", wip(0), 'h10);

        // R6 wrap and overwrite on page 2
        set_ctrl(8'h05);
        send_addr(8'h02);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
        check("R6 wrap ch0", wip(0), 'h33);
        check("R6 wrap ch1", wip(1), 'h44);
        check("R6 overwrite ch2", wip(2), 'h55);
        check("R6 ch3", wip(3), 'h22);
        send_stop(); wait_idle();
        // R7 only valid entries: single byte to ch1
        send_addr(8'h01); send_byte(8'h77);
        send_stop(); wait_idle();
        set_ctrl(8'h00);
        send_addr(8'h00);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        set_ctrl(8'h05);
        send_addr(8'h00);
        read_byte(v); check("R7 page2 ch0 kept", v, 'h33);
        read_byte(v); check("R7 page2 ch1 partial", v, 'h77);
        read_byte(v); check("R6 page2 ch2 overwrite", v, 'h55);
        read_byte(v); check("R6 page2 ch3", v, 'h22);
        check("R4 read moved wiper1", wip(1), 'h77);
        read_byte(v); check("R6 read pointer wrapped", v, 'h33);

        // R2 address decode
        set_ctrl(8'h00);
        for (int i = 0; i < NCH; i++) snap[i] = wip(i);
        send_addr(8'h05); send_byte(8'hFF);
        for (int i = 0; i < NCH; i++) check("R2 unused address write", wip(i), snap[i]);
        read_byte(v); check("R2 unused address reads zero", v, 0);
        send_addr(8'h81); send_byte(8'h5A);
        check("R2 upper address bits ignored", wip(1), 'h5A);
        set_ctrl(8'hFD);
        send_addr(8'h07); read_byte(v);
        check("R3 control upper bits dropped", v, 'h05);

        // R10 save request and R9 busy rejection
        set_ctrl(8'h00);
        send_addr(8'h02); send_byte(8'hC3);
        send_store(2'd2);
        check("R10 save starts busy", int'(busy), 1);
        for (int i = 0; i < NCH; i++) snap[i] = wip(i);
        send_addr(8'h00);
        check("R9 address rejected while busy", int'(rejected), 1);
        send_byte(8'h99);
        check("R9 byte rejected while busy", int'(rejected), 1);
        for (int i = 0; i < NCH; i++) check("R9 wipers hold while busy", wip(i), snap[i]);
        wait_idle();
        send_byte(8'h99);
        check("R9 pointer untouched by rejected address", wip(3), 'h99);
        set_ctrl(8'h01);
        send_addr(8'h02); read_byte(v);
        check("R10 saved into data byte 0", v, 'hC3);
        set_ctrl(8'h03);
        send_store(2'd0);
        check("R10 save refused on page 1", int'(rejected), 1);
        check("R10 no busy on refused save", int'(busy), 0);
        set_ctrl(8'h00);
        wp_en = 1'b0; send_store(2'd1);
        check("R10 protected save ignored", int'(busy), 0);
        wp_en = 1'b1;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule